// File: doc/BRIEF.md
# Dual-Channel Timer Output Compare Unit

This block pairs a 16-bit free-running counter with two compare channels. The counter advances on a tick strobe from a small prescaler. A 2-bit divider select sets that strobe to every clock, or to every 2, 4 or 8 clocks. Each channel keeps a compare value that software loads one byte at a time over a byte-wide register bus. On the tick where the counter steps onto that value, the channel raises its flag. If its output is enabled, the channel also loads a programmed level into its pin latch.

A single request line combines the two flags. It is gated by a global enable and by either one shared enable or one enable per channel. A flag that is not enabled is kept and raises the request as soon as the enables allow it. Software clears a flag in two steps: first any access to the status register while the flag is set, then any access to that channel's low compare byte. Writing a high compare byte suspends that channel's matching until its low byte is written, so a half-updated value can never fire.

Top module: `timer_ocu`

## Requirements
- R1: Each compare register resets to 0x8000. It changes only when software writes its high byte (address 5+2i) or its low byte (address 6+2i), and it reads back at those addresses.
- R2: The counter resets to zero and increments by one on each tick. Its high byte reads at address 3 and its low byte at address 4. With divider select 0 it increments on every clock.
- R3: The counter stepping onto channel i's compare value sets status bit i (status at address 2) on that same edge. If output enable CTRL[2+i] is set (CTRL at address 0), pin i takes level CTRL[4+i] on that edge.
- R4: Both pins are low after reset and stay low until a match loads them.
- R5: A high-byte write suspends matching for that channel until the low-byte write. A counter value reached while matching is suspended is missed and sets no flag.
- R6: A flag clears only when an access (read or write) to the low compare byte follows an access to the status register that was made while the flag was set. A low-byte access on its own, or after a status access made while the flag was clear, leaves the flag set.
- R7: irq_o is high exactly when CTRL[7] (global) is set and some flag i is set with either CTRL[6] (shared) or per-channel enable IEN[i] (IEN at address 1) set. While CTRL[6] is set, IEN is ignored.
- R8: A flag set while its request is disabled stays pending and drives irq_o as soon as the enables are written.
- R9: With output enable clear, a match still sets the flag and can still interrupt, but the pin holds its value.
- R10: Divider select CTRL[1:0] values 0, 1, 2 and 3 give one counter step every 1, 2, 4 and 8 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access (needed for clearing side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| pin_o | output | 2 | Compare output pin latches, bit i for channel i |
| irq_o | output | 1 | Combined compare interrupt request |

## Verification
A register write takes effect on the rising edge that samples its strobe. Flags, pin latches and the counter all move on the edge where the counter reaches a new value. irq_o and reg_rdata are combinational from registers, so both are valid in the same cycle as the state they reflect. The bench drives the bus and samples on the falling edge. It keeps its own count of clocks since reset, which equals the counter value while the divider is 1. It checks a channel on the cycle before its target count and on the cycle of it, so a match one edge early or late is reported.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

   localparam int unsigned ADDR_W    = 4;
   localparam int unsigned NUM_CH    = 2;
   localparam int unsigned DIV_SEL_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
   localparam logic [ADDR_W-1:0] A_CNTH = 4'd3;
   localparam logic [ADDR_W-1:0] A_CNTL = 4'd4;
   localparam logic [ADDR_W-1:0] A_CMP0 = 4'd5;

   // control register, MSB first
   typedef struct packed {
      logic                 glb_ie;
      logic                 shr_ie;
      logic [NUM_CH-1:0]    lvl;
      logic [NUM_CH-1:0]    oe;
      logic [DIV_SEL_W-1:0] div_sel;
   } ctrl_t;

   function automatic logic [ADDR_W-1:0] cmp_hi_addr(input int ch);
      return A_CMP0 + ADDR_W'(2 * ch);
   endfunction

   function automatic logic [ADDR_W-1:0] cmp_lo_addr(input int ch);
      return A_CMP0 + ADDR_W'(2 * ch + 1);
   endfunction

endpackage

// File: rtl/ocu_timebase.sv
module ocu_timebase #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);

   localparam int unsigned PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   // select s keeps the low s prescaler bits in the mask: one tick per 2**s clocks
   always_comb begin
      mask = '0;
      for (int i = 0; i < PRE_W; i++) begin
         if (div_sel > SEL_W'(i)) mask[i] = 1'b1;
      end
   end

   assign tick    = (pre_q & mask) == mask;
   assign cnt_nxt = cnt + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt   <= '0;
      end else begin
         pre_q <= pre_q + PRE_W'(1);
         if (tick) cnt <= cnt_nxt;
      end
   end

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic             acc_lo,
   input  logic             acc_stat,
   input  logic [7:0]       wdata,
   input  logic             oe,
   input  logic             lvl,
   output logic [CNT_W-1:0] cmp,
   output logic             flag,
   output logic             inhib,
   output logic             pin
);

   localparam logic [CNT_W-1:0] CMP_RST = {1'b1, {(CNT_W-1){1'b0}}};

   logic armed;
   logic match;
   logic clr;

   // hit only on the tick that moves the counter onto the compare value
   assign match = tick && !inhib && (cnt_nxt == cmp);
   assign clr   = acc_lo && armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp   <= CMP_RST;
         inhib <= 1'b0;
         armed <= 1'b0;
         flag  <= 1'b0;
         pin   <= 1'b0;
      end else begin
         if (wr_hi) begin
            cmp[CNT_W-1:8] <= wdata[CNT_W-9:0];
            inhib          <= 1'b1;
         end
         if (wr_lo) begin
            cmp[7:0] <= wdata;
            inhib    <= 1'b0;
         end
         if (clr)                  armed <= 1'b0;
         else if (acc_stat && flag) armed <= 1'b1;
         // a new hit outranks a clear in the same cycle
         if (match)    flag <= 1'b1;
         else if (clr) flag <= 1'b0;
         if (match && oe) pin <= lvl;
      end
   end

endmodule

// File: rtl/ocu_irq.sv
module ocu_irq #(
   parameter int unsigned NCH = 2
) (
   input  logic           glb_ie,
   input  logic           shr_ie,
   input  logic [NCH-1:0] ien,
   input  logic [NCH-1:0] flag,
   output logic           irq
);

   logic [NCH-1:0] en;

   assign en  = shr_ie ? {NCH{1'b1}} : ien;
   assign irq = glb_ie && |(flag & en);

endmodule

// File: rtl/timer_ocu.sv
module timer_ocu
   import ocu_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [NUM_CH-1:0] pin_o,
   output logic              irq_o
);

   localparam int unsigned HI_W = CNT_W - 8;

   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
      $error("timer_ocu: CNT_W must lie in 9..16");
   end
   if (NUM_CH != 2) begin : g_bad_nch
      $error("timer_ocu: register map holds exactly two channels");
   end

   ctrl_t                         ctrl_q;
   logic [NUM_CH-1:0]             ien_q;
   logic                          reg_acc;
   logic                          tick;
   logic [CNT_W-1:0]              cnt_q;
   logic [CNT_W-1:0]              cnt_nxt;
   logic [NUM_CH-1:0][CNT_W-1:0]  cmp_q;
   logic [NUM_CH-1:0]             flag;
   logic [NUM_CH-1:0]             inhib;

   assign reg_acc = reg_rd | reg_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
         if (reg_addr == A_IEN)  ien_q  <= reg_wdata[NUM_CH-1:0];
      end
   end

   ocu_timebase #(
      .CNT_W (CNT_W),
      .SEL_W (DIV_SEL_W)
   ) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (ctrl_q.div_sel),
      .tick    (tick),
      .cnt     (cnt_q),
      .cnt_nxt (cnt_nxt)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      ocu_channel #(
         .CNT_W (CNT_W)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .cnt_nxt  (cnt_nxt),
         .wr_hi    (reg_wr  && (reg_addr == cmp_hi_addr(g))),
         .wr_lo    (reg_wr  && (reg_addr == cmp_lo_addr(g))),
         .acc_lo   (reg_acc && (reg_addr == cmp_lo_addr(g))),
         .acc_stat (reg_acc && (reg_addr == A_STAT)),
         .wdata    (reg_wdata),
         .oe       (ctrl_q.oe[g]),
         .lvl      (ctrl_q.lvl[g]),
         .cmp      (cmp_q[g]),
         .flag     (flag[g]),
         .inhib    (inhib[g]),
         .pin      (pin_o[g])
      );
   end

   ocu_irq #(
      .NCH (NUM_CH)
   ) u_irq (
      .glb_ie (ctrl_q.glb_ie),
      .shr_ie (ctrl_q.shr_ie),
      .ien    (ien_q),
      .flag   (flag),
      .irq    (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_q;
         A_IEN:   reg_rdata = 8'(ien_q);
         A_STAT:  reg_rdata = 8'(flag);
         A_CNTH:  reg_rdata = 8'(cnt_q[CNT_W-1:8]);
         A_CNTL:  reg_rdata = cnt_q[7:0];
         default: reg_rdata = '0;
      endcase
      for (int i = 0; i < NUM_CH; i++) begin
         if (reg_addr == cmp_hi_addr(i)) reg_rdata = 8'(cmp_q[i][CNT_W-1:8]);
         if (reg_addr == cmp_lo_addr(i)) reg_rdata = cmp_q[i][7:0];
      end
   end

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = cnt_q[CNT_W-1:8];

endmodule

// File: rtl/ocu_chk.sv
module ocu_chk
   import ocu_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic                         reg_wr,
   input logic                         reg_rd,
   input ctrl_t                        ctrl_q,
   input logic [NUM_CH-1:0]            ien_q,
   input logic                         tick,
   input logic [CNT_W-1:0]             cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] cmp_q,
   input logic [NUM_CH-1:0]            inhib,
   input logic [NUM_CH-1:0]            flag,
   input logic [NUM_CH-1:0]            pin_o,
   input logic                         irq_o
);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt) |-> (cnt == $past(cnt) + CNT_W'(1)) && $past(tick));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ctrl_q.glb_ie);

   // R8
   shared_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.glb_ie && ctrl_q.shr_ie && (|flag)) |-> irq_o);

   // R7
   chan_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.glb_ie && (|(flag & ien_q))) |-> irq_o);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_c
      // R1
      cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(cmp_q[g]) |->
            $past(reg_wr && (reg_addr == cmp_hi_addr(g) || reg_addr == cmp_lo_addr(g))));

      // R3
      flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[g]) |-> $past(tick) && !$past(inhib[g]) && (cnt == $past(cmp_q[g])));

      // R6
      flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag[g]) |-> $past((reg_rd || reg_wr) && reg_addr == cmp_lo_addr(g)));

      // R9
      pin_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(pin_o[g]) |->
            flag[g] && $past(ctrl_q.oe[g]) && (pin_o[g] == $past(ctrl_q.lvl[g])));
   end

endmodule

bind timer_ocu ocu_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .ctrl_q   (ctrl_q),
   .ien_q    (ien_q),
   .tick     (tick),
   .cnt      (cnt_q),
   .cmp_q    (cmp_q),
   .inhib    (inhib),
   .flag     (flag),
   .pin_o    (pin_o),
   .irq_o    (irq_o)
);

// File: tb/timer_ocu_test.sv
module timer_ocu_test;
   import ocu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [1:0]  pin;
   logic        irq;
   logic [15:0] mcnt;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   timer_ocu uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (addr),
      .reg_wr    (wr),
      .reg_rd    (rd),
      .reg_wdata (wdata),
      .reg_rdata (rdata),
      .pin_o     (pin),
      .irq_o     (irq)
   );

   // clocks since reset: the expected counter value while the divider is 1 (R2)
   always_ff @(posedge clk) begin
      if (!rst_n) mcnt <= '0;
      else        mcnt <= mcnt + 16'd1;
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   // combinational look without any strobe
   task automatic look(input logic [3:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      @(negedge clk);
      while (mcnt != v) @(negedge clk);
   endtask

   task automatic set_cmp(input int ch, input logic [15:0] v);
      bus_wr(cmp_hi_addr(ch), v[15:8]);
      bus_wr(cmp_lo_addr(ch), v[7:0]);
   endtask

   task automatic sweep_irq(input logic [1:0] fl);
      for (int v = 0; v < 16; v++) begin
         logic       glb;
         logic       shr;
         logic [1:0] ien;
         logic       exp;
         glb = v[3]; shr = v[2]; ien = v[1:0];
         bus_wr(A_IEN, {6'b0, ien});
         bus_wr(A_CTRL, {glb, shr, 6'h34});
         #1;
         exp = glb && ((fl & (shr ? 2'b11 : ien)) != 2'b00);
         // R7 gating, R8 flags set earlier drive the request once enabled
         chk(shr ? "R7" : "R8", $sformatf("irq flags=%0b en=%0b", fl, v), int'(irq), int'(exp));
      end
      bus_wr(A_IEN, 8'h00);
      bus_wr(A_CTRL, 8'h34);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0]  d;
      logic [7:0]  a;
      logic [15:0] t;
      int          n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      @(negedge clk);
      chk("R4", "pins after reset", int'(pin), 0);
      chk("R7", "irq after reset", int'(irq), 0);
      look(A_STAT, d);         chk("R3", "status after reset", d, 0);
      look(cmp_hi_addr(0), d); chk("R1", "cmp0 hi reset", d, 8'h80);
      look(cmp_lo_addr(0), d); chk("R1", "cmp0 lo reset", d, 8'h00);
      look(cmp_hi_addr(1), d); chk("R1", "cmp1 hi reset", d, 8'h80);
      look(cmp_lo_addr(1), d); chk("R1", "cmp1 lo reset", d, 8'h00);
      @(negedge clk);
      look(A_CNTL, d);         chk("R2", "count low byte", d, mcnt[7:0]);
      look(A_CNTH, d);         chk("R2", "count high byte", d, mcnt[15:8]);
      repeat (5) @(negedge clk);
      look(A_CNTL, d);         chk("R2", "count low byte later", d, mcnt[7:0]);

      // channel 0 match with output enabled, level 1
      bus_wr(A_CTRL, 8'h14);
      t = mcnt + 16'd30;
      set_cmp(0, t);
      wait_cnt(t - 16'd1);
      look(A_STAT, d);         chk("R3", "flag0 one count early", d, 0);
      chk("R4", "pin0 before match", int'(pin), 0);
      wait_cnt(t);
      look(A_STAT, d);         chk("R3", "flag0 at match", d, 1);
      chk("R3", "pin0 takes level", int'(pin), 1);
      chk("R7", "irq with global off", int'(irq), 0);
      look(cmp_lo_addr(0), d); chk("R1", "cmp0 lo unchanged by match", d, t[7:0]);
      look(cmp_hi_addr(0), d); chk("R1", "cmp0 hi unchanged by match", d, t[15:8]);

      // channel 1 match with output disabled
      bus_wr(A_CTRL, 8'h34);
      t = mcnt + 16'd30;
      set_cmp(1, t);
      wait_cnt(t);
      look(A_STAT, d);         chk("R9", "flag1 set with output off", d, 3);
      chk("R9", "pin1 held", int'(pin), 1);

      sweep_irq(2'b11);

      // clearing sequence
      bus_rd(cmp_lo_addr(1));
      look(A_STAT, d);         chk("R6", "low access alone keeps flags", d, 3);
      bus_rd(A_STAT);
      bus_rd(cmp_lo_addr(1));
      look(A_STAT, d);         chk("R6", "status then low read clears flag1", d, 1);

      sweep_irq(2'b01);

      bus_wr(cmp_lo_addr(0), t[7:0]);
      look(A_STAT, d);         chk("R6", "armed ch0 cleared by low write", d, 0);

      bus_rd(A_STAT);
      t = mcnt + 16'd30;
      set_cmp(1, t);
      wait_cnt(t);
      look(A_STAT, d);         chk("R3", "flag1 second match", d, 2);
      bus_rd(cmp_lo_addr(1));
      look(A_STAT, d);         chk("R6", "status read while clear does not arm", d, 2);
      bus_wr(A_STAT, 8'h00);
      bus_rd(cmp_lo_addr(1));
      look(A_STAT, d);         chk("R6", "status write then low read clears", d, 0);

      // inhibit window on channel 0, level now 0
      bus_wr(A_CTRL, 8'h24);
      t = mcnt + 16'd40;
      set_cmp(0, t);
      bus_wr(cmp_hi_addr(0), t[15:8]);
      wait_cnt(t + 16'd2);
      look(A_STAT, d);         chk("R5", "no flag while inhibited", d, 0);
      chk("R5", "pin0 unchanged while inhibited", int'(pin), 1);
      bus_wr(cmp_lo_addr(0), t[7:0]);
      look(A_STAT, d);         chk("R5", "missed match stays missed", d, 0);
      t = mcnt + 16'd30;
      set_cmp(0, t);
      wait_cnt(t);
      look(A_STAT, d);         chk("R5", "compares resume after low write", d, 1);
      chk("R3", "pin0 takes level 0", int'(pin), 0);

      // divider sweep
      for (int sel = 0; sel < 4; sel++) begin
         bus_wr(A_CTRL, 8'(sel));
         @(negedge clk);
         look(A_CNTL, a);
         n = 0;
         do begin
            @(negedge clk); look(A_CNTL, d); n++;
         end while (d == a && n < 20);
         a = d;
         n = 0;
         do begin
            @(negedge clk); look(A_CNTL, d); n++;
         end while (d == a && n < 20);
         chk("R10", $sformatf("clocks per step sel=%0d", sel), n, 1 << sel);
         chk("R10", $sformatf("single step sel=%0d", sel), int'(d), int'(a + 8'd1));
      end

      finish_run();
   end

endmodule